// File: doc/BRIEF.md
# Triggered Event Data Injector

This block holds one event in an on-chip word memory and replays it as a 16-bit word stream each time it sees a trigger. The memory and a small set of control registers are loaded through a write-only bus port. The trigger comes from one of two sources. The first is an external pin, which is synchronized and edge-detected. The second is an internal generator that fires once every programmable number of clock cycles. Each accepted trigger sends the event, word by word, to any subset of the output channels chosen by an enable mask.

Injection is started and stopped by command bits. A loop mode stops the injector by itself after a programmed number of events and raises a done flag. An external busy input can be enabled to hold off new events; an event already in progress always completes. A trigger that lands during playback is dropped and counted. The block is meant to drive a downstream receiver with repeatable test events at a chosen rate.

Top module: `evt_injector`

## Requirements
- R1: A write with `bus_addr[ADDR_W]`=0 stores `bus_wdata` in the event memory at word `bus_addr[ADDR_W-1:0]`. A write with `bus_addr[ADDR_W]`=1 goes to a register picked by `bus_addr[1:0]`: 0 = control, 1 = event length in words, 2 = divider, 3 = loop limit. The control bits are: bit 0 start (arm), bit 1 stop (disarm), bit 2 internal trigger select, bit 3 loop enable, bit 4 busy gating enable.
- R2: After reset, `out_valid`, `armed`, `done` and `ovf_count` are all zero.
- R3: An accepted trigger plays memory words 0 to length-1 in order, one per clock on consecutive cycles, each with its channel's `out_valid` high.
- R4: With external triggering, a rising edge on `ext_trig` (after synchronization) is a trigger. Triggers have no effect while the injector is not armed. A stop command disarms it, and stop wins over start in the same write.
- R5: With internal triggering selected and the injector armed, a trigger fires once every divider+1 clock cycles, and `ext_trig` is ignored.
- R6: The `chan_en` mask is sampled when a trigger is accepted. Channel i raises `out_valid[i]` for that event only if bit i was set. Outside its valid cycles a channel's data is zero.
- R7: A trigger that arrives while an event is still playing, including in the cycle of the last word, starts nothing and increments `ovf_count`, which saturates. A start command clears `ovf_count`.
- R8: While busy gating is enabled and the synchronized `ext_busy` is high, triggers are dropped without being counted. An event that is already playing when busy rises still plays in full.
- R9: In loop mode, accepting the event whose count reaches the loop limit clears `armed` and sets `done`. That event still plays. A start command clears `done` and the event count.
- R10: With event length zero, a trigger starts no playback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for memory and registers |
| bus_addr | input | ADDR_W+1 | Top bit selects registers; low bits give the word or register address |
| bus_wdata | input | DATA_W | Write data |
| ext_trig | input | 1 | External trigger, asynchronous |
| ext_busy | input | 1 | External busy, asynchronous |
| chan_en | input | N_CH | Channel enable mask, sampled at trigger acceptance |
| out_data | output | N_CH*DATA_W | Output words, channel i in bits [i*DATA_W +: DATA_W] |
| out_valid | output | N_CH | Per-channel word valid strobe |
| armed | output | 1 | Injector accepts triggers |
| done | output | 1 | Loop limit reached |
| ovf_count | output | OVF_W | Count of triggers dropped during playback |

## Verification
A new trigger and the last word of the current event can fall in the same cycle. The bench provokes this with the internal generator. When the trigger period equals the event length, every second tick hits the final playback cycle. The bench expects that tick to be counted as an overflow, with no second event started, and it checks the next tick starts an event 12 cycles after the first. When the period is one longer than the length, events run back to back with no overflow and a start spacing of exactly 7 cycles. The word-by-word scoreboard judges both cases, along with the overflow count and the measured start-to-start gaps.

// File: rtl/evt_pkg.sv
package evt_pkg;
   // register select codes (low address bits, register space)
   localparam logic [1:0] SEL_CTRL  = 2'd0;
   localparam logic [1:0] SEL_LEN   = 2'd1;
   localparam logic [1:0] SEL_DIV   = 2'd2;
   localparam logic [1:0] SEL_LOOP  = 2'd3;
   // control word bit positions
   localparam int CB_START = 0;
   localparam int CB_STOP  = 1;
   localparam int CB_INT   = 2;
   localparam int CB_LOOP  = 3;
   localparam int CB_BUSY  = 4;

   typedef struct packed {
      logic int_sel;
      logic loop_en;
      logic busy_gate;
   } evt_mode_t;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last;

   initial assert (STAGES >= 1) else $error("evt_sync: STAGES must be at least 1");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain[0] <= din;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         last <= chain[STAGES-1];
      end
   end

   assign lvl  = chain[STAGES-1];
   assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/evt_tick_gen.sv
module evt_tick_gen #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] div,
   output logic         tick
);
   logic [W-1:0] cnt;

   initial assert (W >= 1) else $error("evt_tick_gen: W must be positive");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!en)        cnt <= '0;
      else if (cnt == div) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign tick = en & (cnt == div);

   // R5: with a nonzero divider, two ticks never sit on adjacent cycles
   p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/evt_mem.sv
module evt_mem #(
   parameter int DW = 16,
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rd_en,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;
   logic [DW-1:0] store [DEPTH];

   initial assert (AW >= 2 && AW <= 12) else $error("evt_mem: AW out of range");

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
      if (rd_en) rdata <= store[raddr];
   end
endmodule

// File: rtl/evt_injector.sv
module evt_injector
   import evt_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 10,
   parameter int N_CH        = 2,
   parameter int OVF_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit ZERO_IDLE   = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_we,
   input  logic [ADDR_W:0]        bus_addr,
   input  logic [DATA_W-1:0]      bus_wdata,
   input  logic                   ext_trig,
   input  logic                   ext_busy,
   input  logic [N_CH-1:0]        chan_en,
   output logic [N_CH*DATA_W-1:0] out_data,
   output logic [N_CH-1:0]        out_valid,
   output logic                   armed,
   output logic                   done,
   output logic [OVF_W-1:0]       ovf_count
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int LEN_W = ADDR_W + 1;

   initial begin
      assert (ADDR_W >= 2) else $error("evt_injector: ADDR_W must be at least 2");
      assert (DATA_W >= LEN_W) else $error("evt_injector: DATA_W too narrow for length");
      assert (N_CH >= 1) else $error("evt_injector: N_CH must be positive");
      assert (OVF_W >= 1) else $error("evt_injector: OVF_W must be positive");
   end

   // ---------------- bus decode and registers ----------------
   logic wr_reg, wr_mem, start_p, stop_p;
   evt_mode_t         mode;
   logic [LEN_W-1:0]  len_q;
   logic [DATA_W-1:0] div_q, loop_lim_q, loop_cnt;

   assign wr_reg  = bus_we &  bus_addr[ADDR_W];
   assign wr_mem  = bus_we & ~bus_addr[ADDR_W];
   assign start_p = wr_reg && bus_addr[1:0] == SEL_CTRL && bus_wdata[CB_START];
   assign stop_p  = wr_reg && bus_addr[1:0] == SEL_CTRL && bus_wdata[CB_STOP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode       <= '0;
         len_q      <= '0;
         div_q      <= '0;
         loop_lim_q <= '0;
      end else if (wr_reg) begin
         case (bus_addr[1:0])
            SEL_CTRL: mode <= '{int_sel:   bus_wdata[CB_INT],
                                loop_en:   bus_wdata[CB_LOOP],
                                busy_gate: bus_wdata[CB_BUSY]};
            SEL_LEN:  len_q      <= bus_wdata[LEN_W-1:0];
            SEL_DIV:  div_q      <= bus_wdata;
            SEL_LOOP: loop_lim_q <= bus_wdata;
            default:  ;
         endcase
      end
   end

   // ---------------- trigger sources ----------------
   logic ext_rise, ext_lvl, busy_s, busy_rise, tick;

   evt_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
      .clk(clk), .rst_n(rst_n), .din(ext_trig), .lvl(ext_lvl), .rise(ext_rise));

   evt_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
      .clk(clk), .rst_n(rst_n), .din(ext_busy), .lvl(busy_s), .rise(busy_rise));

   evt_tick_gen #(.W(DATA_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(armed & mode.int_sel), .div(div_q), .tick(tick));

   // ---------------- playback control ----------------
   logic              playing, vld_q, trig, accept, gated, loop_hit;
   logic [ADDR_W-1:0] rd_addr, last_addr;
   logic [LEN_W-1:0]  eff_len;
   logic [N_CH-1:0]   mask_q;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W:0]   next_cnt;

   assign eff_len   = (len_q > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : len_q;
   assign last_addr = ADDR_W'(eff_len - 1'b1);
   assign trig      = armed & (mode.int_sel ? tick : ext_rise);
   assign gated     = mode.busy_gate & busy_s;
   assign accept    = trig & ~playing & ~gated & (len_q != '0);
   assign next_cnt  = {1'b0, loop_cnt} + 1'b1;
   assign loop_hit  = mode.loop_en && (next_cnt >= {1'b0, loop_lim_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         done     <= 1'b0;
         loop_cnt <= '0;
      end else if (stop_p) begin
         armed <= 1'b0;
      end else if (start_p) begin
         armed    <= 1'b1;
         done     <= 1'b0;
         loop_cnt <= '0;
      end else if (accept) begin
         loop_cnt <= next_cnt[DATA_W-1:0];
         if (loop_hit) begin
            armed <= 1'b0;
            done  <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_count <= '0;
      end else if (start_p && !stop_p) begin
         ovf_count <= '0;
      end else if (trig && playing && !(&ovf_count)) begin
         ovf_count <= ovf_count + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         playing <= 1'b0;
         rd_addr <= '0;
         mask_q  <= '0;
         vld_q   <= 1'b0;
      end else begin
         vld_q <= playing;
         if (accept) begin
            playing <= 1'b1;
            rd_addr <= '0;
            mask_q  <= chan_en;
         end else if (playing) begin
            if (rd_addr == last_addr) playing <= 1'b0;
            else                      rd_addr <= rd_addr + 1'b1;
         end
      end
   end

   evt_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
      .clk(clk), .we(wr_mem), .waddr(bus_addr[ADDR_W-1:0]), .wdata(bus_wdata),
      .rd_en(playing), .raddr(rd_addr), .rdata(rd_data));

   // ---------------- output channels ----------------
   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      assign out_valid[c] = vld_q & mask_q[c];
      if (ZERO_IDLE) begin : g_zero
         assign out_data[c*DATA_W +: DATA_W] = out_valid[c] ? rd_data : '0;
      end else begin : g_raw
         assign out_data[c*DATA_W +: DATA_W] = rd_data;
      end
   end

   // ---------------- assertions ----------------
   // R3: a valid word only follows a cycle of playback
   p_valid_after_play_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|out_valid) |-> $past(playing));
   // R3: the read pointer never passes the last word
   p_addr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      playing |-> rd_addr <= last_addr);
   // R4: a stop command leaves the injector disarmed
   p_stop_disarms_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> !armed);
   // R7: the drop counter only moves while an event plays (or on start)
   p_ovf_in_play_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(start_p) && ovf_count != $past(ovf_count)) |-> $past(playing));
   // R8: gated busy keeps an idle injector idle
   p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode.busy_gate && busy_s && !playing) |=> !playing);
   // R9: done rises only together with disarm
   p_done_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> !armed);
   // R10: zero length never starts playback
   p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (len_q == '0 && !playing) |=> !playing);
endmodule

// File: tb/sim_evt_injector.sv
module sim_evt_injector;
   localparam int DW = 16;
   localparam int AW = 10;
   localparam int NC = 2;
   localparam logic [AW:0] R_CTRL = 11'h400;
   localparam logic [AW:0] R_LEN  = 11'h401;
   localparam logic [AW:0] R_DIV  = 11'h402;
   localparam logic [AW:0] R_LOOP = 11'h403;
   localparam logic [15:0] C_START = 16'h01, C_STOP = 16'h02, C_INT = 16'h04,
                           C_LOOP = 16'h08, C_BUSY = 16'h10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_we = 1'b0;
   logic [AW:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic ext_trig = 1'b0, ext_busy = 1'b0;
   logic [NC-1:0] chan_en = '0;
   logic [NC*DW-1:0] out_data;
   logic [NC-1:0] out_valid;
   logic armed, done;
   logic [7:0] ovf_count;

   evt_injector u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .ext_trig(ext_trig), .ext_busy(ext_busy),
      .chan_en(chan_en), .out_data(out_data), .out_valid(out_valid),
      .armed(armed), .done(done), .ovf_count(ovf_count));

   always #10 clk = ~clk;

   int errors = 0, checks = 0;
   int words = 0, nstart = 0, last_start = 0, cyc = 0;
   int gaps [8];
   bit prev_v0 = 1'b0, finished = 1'b0;
   logic [DW-1:0] model [64];
   logic [DW-1:0] q0 [$];
   logic [DW-1:0] q1 [$];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic expect_event(input logic [NC-1:0] m, input int len);
      for (int i = 0; i < len; i++) begin
         if (m[0]) q0.push_back(model[i]);
         if (m[1]) q1.push_back(model[i]);
      end
   endtask

   task automatic pulse_ext();
      @(negedge clk); ext_trig = 1'b1;
      repeat (3) @(negedge clk);
      ext_trig = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (out_valid[0]) begin
            words++;
            if (q0.size() == 0) check(1'b0, "R6 unexpected ch0 word", int'(out_data[15:0]), -1);
            else begin
               automatic logic [DW-1:0] e = q0.pop_front();
               check(out_data[15:0] == e, "R1/R3 ch0 word", int'(out_data[15:0]), int'(e));
            end
         end
         if (out_valid[1]) begin
            words++;
            if (q1.size() == 0) check(1'b0, "R6 unexpected ch1 word", int'(out_data[31:16]), -1);
            else begin
               automatic logic [DW-1:0] e = q1.pop_front();
               check(out_data[31:16] == e, "R1/R3 ch1 word", int'(out_data[31:16]), int'(e));
            end
         end
         if (out_valid[0] && !prev_v0) begin
            if (nstart > 0 && nstart <= 8) gaps[nstart-1] = cyc - last_start;
            last_start = cyc;
            nstart++;
         end
         prev_v0 = out_valid[0];
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog act=hung exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int w0;
      idle(4);
      // R2: reset state
      check(out_valid == '0, "R2 out_valid", int'(out_valid), 0);
      check(!armed && !done, "R2 armed/done", int'({armed, done}), 0);
      check(ovf_count == 0, "R2 ovf_count", int'(ovf_count), 0);
      rst_n = 1'b1;
      idle(2);

      // R1: load memory
      for (int i = 0; i < 64; i++) begin
         model[i] = 16'hC000 ^ 16'(i * 37 + 5);
         bus_write(11'(i), model[i]);
      end
      bus_write(R_LEN, 16'd5);

      // R4: not armed, trigger ignored
      chan_en = 2'b01;
      w0 = words;
      pulse_ext(); idle(12);
      check(words == w0, "R4 unarmed trigger ignored", words - w0, 0);

      // R3/R4: armed, external trigger, channel 0
      bus_write(R_CTRL, C_START);
      check(armed, "R4 armed after start", int'(armed), 1);
      expect_event(2'b01, 5);
      pulse_ext(); idle(12);
      check(q0.size() == 0, "R3 ch0 event drained", q0.size(), 0);

      // R6: both channels, then only channel 1
      chan_en = 2'b11; expect_event(2'b11, 5);
      pulse_ext(); idle(12);
      check(q0.size() == 0 && q1.size() == 0, "R6 both drained", q0.size() + q1.size(), 0);
      chan_en = 2'b10; expect_event(2'b10, 5);
      w0 = words;
      pulse_ext(); idle(12);
      check(words - w0 == 5, "R6 ch1 only word count", words - w0, 5);

      // R7: trigger during playback
      chan_en = 2'b01;
      bus_write(R_LEN, 16'd20);
      expect_event(2'b01, 20);
      pulse_ext(); pulse_ext(); idle(30);
      check(ovf_count == 1, "R7 overflow counted", int'(ovf_count), 1);
      check(q0.size() == 0, "R7 single event played", q0.size(), 0);

      // R5/R9: internal trigger period and loop limit
      bus_write(R_LEN, 16'd4);
      bus_write(R_DIV, 16'd9);
      bus_write(R_LOOP, 16'd3);
      nstart = 0;
      expect_event(2'b01, 4); expect_event(2'b01, 4); expect_event(2'b01, 4);
      bus_write(R_CTRL, C_START | C_INT | C_LOOP);
      check(ovf_count == 0, "R7 start clears ovf", int'(ovf_count), 0);
      idle(70);
      check(nstart == 3, "R9 loop event count", nstart, 3);
      check(gaps[0] == 10, "R5 period first", gaps[0], 10);
      check(gaps[1] == 10, "R5 period second", gaps[1], 10);
      check(done && !armed, "R9 done and disarmed", int'({done, armed}), 2);

      // R7 boundary: trigger on the last word cycle
      bus_write(R_LEN, 16'd6);
      bus_write(R_DIV, 16'd5);
      bus_write(R_LOOP, 16'd2);
      nstart = 0;
      expect_event(2'b01, 6); expect_event(2'b01, 6);
      bus_write(R_CTRL, C_START | C_INT | C_LOOP);
      check(!done, "R9 start clears done", int'(done), 0);
      idle(60);
      check(ovf_count == 1, "R7 last-word trigger dropped", int'(ovf_count), 1);
      check(nstart == 2 && gaps[0] == 12, "R7 second event after drop", gaps[0], 12);

      // R5 boundary: period one longer than length, back to back
      bus_write(R_DIV, 16'd6);
      nstart = 0;
      expect_event(2'b01, 6); expect_event(2'b01, 6);
      bus_write(R_CTRL, C_START | C_INT | C_LOOP);
      idle(60);
      check(ovf_count == 0, "R5 back-to-back no drop", int'(ovf_count), 0);
      check(nstart == 2 && gaps[0] == 7, "R5 back-to-back gap", gaps[0], 7);

      // R5: external edges ignored in internal mode (injector disarmed by loop now,
      // re-arm with a long divider so no tick falls inside the window)
      bus_write(R_DIV, 16'd1000);
      bus_write(R_CTRL, C_START | C_INT);
      w0 = words;
      pulse_ext(); idle(12);
      check(words == w0, "R5 external ignored in internal mode", words - w0, 0);

      // R8: busy gating
      bus_write(R_LEN, 16'd5);
      bus_write(R_CTRL, C_START | C_BUSY);
      ext_busy = 1'b1; idle(4);
      w0 = words;
      pulse_ext(); idle(12);
      check(words == w0, "R8 busy blocks trigger", words - w0, 0);
      check(ovf_count == 0, "R8 blocked trigger not counted", int'(ovf_count), 0);
      ext_busy = 1'b0; idle(4);
      expect_event(2'b01, 5);
      pulse_ext(); idle(12);
      check(q0.size() == 0, "R8 plays after release", q0.size(), 0);
      bus_write(R_LEN, 16'd20);
      expect_event(2'b01, 20);
      pulse_ext();
      ext_busy = 1'b1;
      idle(30);
      check(q0.size() == 0, "R8 event completes under busy", q0.size(), 0);
      ext_busy = 1'b0; idle(4);

      // R10: zero length
      bus_write(R_LEN, 16'd0);
      w0 = words;
      pulse_ext(); idle(12);
      check(words == w0, "R10 zero length no playback", words - w0, 0);

      // R4: stop disarms; stop beats start
      bus_write(R_LEN, 16'd5);
      bus_write(R_CTRL, C_STOP | C_START);
      check(!armed, "R4 stop wins over start", int'(armed), 0);
      w0 = words;
      pulse_ext(); idle(12);
      check(words == w0, "R4 disarmed trigger ignored", words - w0, 0);

      check(q0.size() == 0 && q1.size() == 0, "R3 scoreboard empty", q0.size() + q1.size(), 0);
      finished = 1'b1;
      summary();
      $finish;
   end
endmodule